// File: doc/BRIEF.md
# Variable-Length Instruction Prefetch Unit

This block feeds an execution engine for an 8-bit processor whose instructions occupy one to four bytes. It reads program memory one byte per clock through a synchronous read port with one cycle of latency. It looks up the instruction length from the first byte it receives, gathers the remaining operand bytes, and offers the whole instruction through a valid/ready hand-over.

Fetching overlaps execution. The read of the next opcode starts in the same cycle that the engine accepts the current instruction, so the engine waits only when the next instruction has more bytes than the current one has execution cycles. Every cycle in which the engine is waiting and nothing is on offer is flagged on a stall output.

The block owns the 16-bit fetch address. The address steps by one for every byte read. On a redirect the block jumps either to an absolute address or to a relative target computed by its own adder. A redirect throws away any bytes that have been partly collected.

Top module: `vl_prefetch`

## Requirements
- R1: While reset is held and until the first instruction is fully collected, `insn_valid_o` is low. In the first cycle after reset is released, the block issues a read at `RESET_ADDR` (default 16'h0040).
- R2: The instruction length is `code+1`. Here `code` is the 2-bit entry of `LEN_MAP` selected by the low nibble of the opcode, with entry n at bits [2n+1:2n]. With the default map the length equals opcode[1:0]+1.
- R3: At most one byte is read per clock. Read data is taken in the cycle after its request. Two reads in consecutive cycles with no redirect between them use consecutive addresses (+1, modulo 2^16).
- R4: An offered instruction presents the opcode on `insn_op_o` and operand k (k = 1..3) on `insn_args_o[8k-1:8k-8]`. Bytes beyond the instruction length read as zero. The instruction's own address is on `insn_pc_o` and its byte count is on `insn_len_o`.
- R5: If an instruction is accepted in cycle t, the opcode read for the next one is issued in cycle t. A next instruction of B bytes is offered from cycle t+B+1. `insn_valid_o` is low in cycle t+1.
- R6: While an instruction is offered and not accepted, and no redirect is present, the offer stays valid with unchanged opcode, address and length, and no memory read is issued.
- R7: `stall_o` is high exactly in the cycles where `insn_ready_i` is high and `insn_valid_o` is low. Consider an engine that drops ready for C cycles after each acceptance (C is 1 for opcode 8'h00). Between an instruction taking C cycles and a following B-byte instruction, it sees max(0, B-C) stall cycles.
- R8: A redirect with `redir_rel_i` low makes the next cycle a read at `redir_arg_i` with `insn_valid_o` low. Bytes of a partly collected instruction, including a read still in flight, are discarded.
- R9: A redirect with `redir_rel_i` high targets the address that follows the most recently accepted instruction (its address plus its length), plus `redir_arg_i[7:0]` sign-extended, modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_rd_o | output | 1 | Read request to program memory this cycle |
| mem_addr_o | output | 16 | Read address |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the request |
| redir_i | input | 1 | Redirect fetch this cycle |
| redir_rel_i | input | 1 | 1: relative displacement, 0: absolute target |
| redir_arg_i | input | 16 | Absolute target, or displacement in bits [7:0] |
| insn_valid_o | output | 1 | A complete instruction is offered |
| insn_ready_i | input | 1 | Execution engine takes the offered instruction |
| insn_op_o | output | 8 | Opcode byte |
| insn_args_o | output | 24 | Operand bytes, first operand lowest |
| insn_len_o | output | 3 | Instruction length in bytes (1..4) |
| insn_pc_o | output | 16 | Address of the opcode byte |
| stall_o | output | 1 | Engine waiting with no instruction on offer |

## Verification
The hardest case to reach from the ports is a redirect that lands while the next instruction is only partly gathered, with its first read still in flight. The stimulus gets there by using an engine model that lowers ready for each instruction's execution cycles. Each redirect is issued in the cycle right after an acceptance, which is exactly when the next opcode read is outstanding. The first jump is absolute and goes near the top of the address space, so that a later relative jump must wrap through zero and a further one uses a negative displacement.

// File: rtl/pf_pkg.sv
// Shared definitions for the variable-length prefetch unit.
// Assumes: nothing beyond the types declared here.
package pf_pkg;

    // Collection state of the fetch sequencer
    typedef enum logic [1:0] {
        PF_START   = 2'd0,   // request an opcode at the current address
        PF_COLLECT = 2'd1,   // opcode and operand bytes are arriving
        PF_HOLD    = 2'd2    // complete instruction offered downstream
    } pf_state_e;

endpackage

// File: rtl/pf_len_lut.sv
// Partial decode: maps the low opcode bits to an instruction length.
// Assumes: LEN_MAP holds one CODE_W-bit code per selector value, entry n at
// bits [n*CODE_W +: CODE_W]; the length is code + 1.
module pf_len_lut #(
    parameter int MAX_BYTES = 4,
    parameter int SEL_W     = 4,
    parameter int CODE_W    = $clog2(MAX_BYTES),
    parameter int LEN_W     = $clog2(MAX_BYTES + 1),
    parameter logic [(2**SEL_W)*CODE_W-1:0] LEN_MAP = 32'hE4E4_E4E4
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [LEN_W-1:0] len_o
);

    logic [CODE_W-1:0] code;

    // Table lookup followed by the +1 bias
    always_comb begin
        code  = LEN_MAP[int'(sel_i) * CODE_W +: CODE_W];
        len_o = LEN_W'(code) + LEN_W'(1);
    end

endmodule

// File: rtl/pf_pc_unit.sv
// Fetch address register with a relative-target adder.
// Assumes: step_i and redir_i may both be high; the redirect wins.
// The relative base is the address after the last accepted instruction.
module pf_pc_unit #(
    parameter int ADDR_W     = 16,
    parameter int LEN_W      = 3,
    parameter int DISP_W     = 8,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 16'h0040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              retire_i,
    input  logic [ADDR_W-1:0] retire_pc_i,
    input  logic [LEN_W-1:0]  retire_len_i,
    input  logic              redir_i,
    input  logic              redir_rel_i,
    input  logic [ADDR_W-1:0] redir_arg_i,
    output logic [ADDR_W-1:0] pc_o
);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] target;

    // Sign-extend the displacement and choose the jump target
    always_comb begin
        disp_ext = {{(ADDR_W-DISP_W){redir_arg_i[DISP_W-1]}}, redir_arg_i[DISP_W-1:0]};
        target   = redir_rel_i ? (base_q + disp_ext) : redir_arg_i;
    end

    // Fetch address: reset value, redirect target, or step by one byte
    always_ff @(posedge clk) begin
        if (!rst_n)       pc_q <= RESET_ADDR;
        else if (redir_i) pc_q <= target;
        else if (step_i)  pc_q <= pc_q + ADDR_W'(1);
    end

    // Relative base: address that follows the instruction just accepted
    always_ff @(posedge clk) begin
        if (!rst_n)        base_q <= RESET_ADDR;
        else if (retire_i) base_q <= retire_pc_i + ADDR_W'(retire_len_i);
    end

    assign pc_o = pc_q;

endmodule

// File: rtl/pf_assembler.sv
// Collects opcode and operand bytes into the hand-over register.
// Assumes: index 0 is the opcode and clears all operand slots; indices
// 1..MAX_BYTES-1 fill the operand slots in order.
module pf_assembler #(
    parameter int DATA_W    = 8,
    parameter int MAX_BYTES = 4,
    parameter int ADDR_W    = 16,
    parameter int IDX_W     = $clog2(MAX_BYTES)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              open_i,
    input  logic [ADDR_W-1:0]                 open_pc_i,
    input  logic                              cap_i,
    input  logic [IDX_W-1:0]                  cap_idx_i,
    input  logic [DATA_W-1:0]                 cap_byte_i,
    output logic [DATA_W-1:0]                 op_o,
    output logic [(MAX_BYTES-1)*DATA_W-1:0]   args_o,
    output logic [ADDR_W-1:0]                 pc_o
);

    logic [DATA_W-1:0]                   op_q;
    logic [ADDR_W-1:0]                   pc_q;
    logic [MAX_BYTES-2:0][DATA_W-1:0]    slot_q;

    // Opcode byte register
    always_ff @(posedge clk) begin
        if (!rst_n)                          op_q <= '0;
        else if (cap_i && cap_idx_i == '0)   op_q <= cap_byte_i;
    end

    // Address of the opcode, latched when its read is issued
    always_ff @(posedge clk) begin
        if (!rst_n)      pc_q <= '0;
        else if (open_i) pc_q <= open_pc_i;
    end

    for (genvar g = 0; g < MAX_BYTES - 1; g++) begin : g_slot
        // Operand slot g: cleared by a new opcode, loaded by its own index
        always_ff @(posedge clk) begin
            if (!rst_n)                                   slot_q[g] <= '0;
            else if (cap_i && cap_idx_i == '0)            slot_q[g] <= '0;
            else if (cap_i && cap_idx_i == IDX_W'(g + 1)) slot_q[g] <= cap_byte_i;
        end
    end

    assign op_o   = op_q;
    assign args_o = slot_q;
    assign pc_o   = pc_q;

endmodule

// File: rtl/vl_prefetch.sv
// Variable-length instruction prefetch: one byte read per clock, length
// from the opcode, complete instruction offered by valid/ready, and the next
// opcode read issued in the same cycle the current one is accepted.
// Assumes: program memory answers one cycle after each request, and the
// engine raises ready only when it can start a new instruction.
module vl_prefetch #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int MAX_BYTES = 4,
    parameter int SEL_W     = 4,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 16'h0040,
    parameter logic [(2**SEL_W)*$clog2(MAX_BYTES)-1:0] LEN_MAP = 32'hE4E4_E4E4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    output logic                             mem_rd_o,
    output logic [ADDR_W-1:0]                mem_addr_o,
    input  logic [DATA_W-1:0]                mem_rdata_i,
    input  logic                             redir_i,
    input  logic                             redir_rel_i,
    input  logic [ADDR_W-1:0]                redir_arg_i,
    output logic                             insn_valid_o,
    input  logic                             insn_ready_i,
    output logic [DATA_W-1:0]                insn_op_o,
    output logic [(MAX_BYTES-1)*DATA_W-1:0]  insn_args_o,
    output logic [$clog2(MAX_BYTES+1)-1:0]   insn_len_o,
    output logic [ADDR_W-1:0]                insn_pc_o,
    output logic                             stall_o
);
    import pf_pkg::*;

    localparam int CODE_W = $clog2(MAX_BYTES);
    localparam int LEN_W  = $clog2(MAX_BYTES + 1);

    pf_state_e          state_q;
    logic [LEN_W-1:0]   req_cnt_q;
    logic               infl_q;
    logic [CODE_W-1:0]  infl_idx_q;
    logic [LEN_W-1:0]   len_q;

    logic [LEN_W-1:0]   lut_len;
    logic [LEN_W-1:0]   len_now;
    logic               first_arr;
    logic               take;
    logic               open_new;
    logic               more;
    logic               fetch;
    logic               last;
    logic [ADDR_W-1:0]  pc;

    pf_len_lut #(
        .MAX_BYTES (MAX_BYTES),
        .SEL_W     (SEL_W),
        .CODE_W    (CODE_W),
        .LEN_W     (LEN_W),
        .LEN_MAP   (LEN_MAP)
    ) u_lut (
        .sel_i (mem_rdata_i[SEL_W-1:0]),
        .len_o (lut_len)
    );

    // Request and completion decisions for this cycle
    always_comb begin
        first_arr = infl_q && (infl_idx_q == '0);
        len_now   = first_arr ? lut_len : len_q;
        take      = (state_q == PF_HOLD) && insn_ready_i;
        open_new  = !redir_i && ((state_q == PF_START) || take);
        more      = !redir_i && (state_q == PF_COLLECT) && (req_cnt_q < len_now);
        fetch     = open_new || more;
        last      = (state_q == PF_COLLECT) && infl_q &&
                    ((LEN_W'(infl_idx_q) + LEN_W'(1)) == len_now);
    end

    // Sequencer state: redirect restarts, last byte offers, acceptance refetches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PF_START;
        end else if (redir_i) begin
            state_q <= PF_START;
        end else begin
            case (state_q)
                PF_START:   state_q <= PF_COLLECT;
                PF_COLLECT: if (last) state_q <= PF_HOLD;
                PF_HOLD:    if (take) state_q <= PF_COLLECT;
                default:    state_q <= PF_START;
            endcase
        end
    end

    // Byte counters: how many reads issued, which one is in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_cnt_q  <= '0;
            infl_q     <= 1'b0;
            infl_idx_q <= '0;
        end else begin
            infl_q     <= fetch;
            infl_idx_q <= open_new ? '0 : req_cnt_q[CODE_W-1:0];
            if (open_new)  req_cnt_q <= LEN_W'(1);
            else if (more) req_cnt_q <= req_cnt_q + LEN_W'(1);
        end
    end

    // Length of the instruction being collected, fixed by its opcode
    always_ff @(posedge clk) begin
        if (!rst_n)                      len_q <= '0;
        else if (first_arr && !redir_i)  len_q <= lut_len;
    end

    pf_pc_unit #(
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W),
        .DISP_W     (DATA_W),
        .RESET_ADDR (RESET_ADDR)
    ) u_pc (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_i       (fetch),
        .retire_i     (take),
        .retire_pc_i  (insn_pc_o),
        .retire_len_i (len_q),
        .redir_i      (redir_i),
        .redir_rel_i  (redir_rel_i),
        .redir_arg_i  (redir_arg_i),
        .pc_o         (pc)
    );

    pf_assembler #(
        .DATA_W    (DATA_W),
        .MAX_BYTES (MAX_BYTES),
        .ADDR_W    (ADDR_W),
        .IDX_W     (CODE_W)
    ) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .open_i     (open_new),
        .open_pc_i  (pc),
        .cap_i      (infl_q && !redir_i),
        .cap_idx_i  (infl_idx_q),
        .cap_byte_i (mem_rdata_i),
        .op_o       (insn_op_o),
        .args_o     (insn_args_o),
        .pc_o       (insn_pc_o)
    );

    assign mem_rd_o     = fetch;
    assign mem_addr_o   = pc;
    assign insn_valid_o = (state_q == PF_HOLD);
    assign insn_len_o   = len_q;
    assign stall_o      = insn_ready_i && !insn_valid_o;

endmodule

// File: rtl/vl_prefetch_chk.sv
// Protocol checker for the prefetch unit, bound to every instance.
// Assumes: synchronous active-low reset; seen_q marks that the previous
// cycle was already out of reset.
module vl_prefetch_chk #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int MAX_BYTES = 4,
    parameter int LEN_W     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              redir_i,
    input logic              redir_rel_i,
    input logic [ADDR_W-1:0] redir_arg_i,
    input logic              insn_valid_o,
    input logic              insn_ready_i,
    input logic [DATA_W-1:0] insn_op_o,
    input logic [LEN_W-1:0]  insn_len_o,
    input logic [ADDR_W-1:0] insn_pc_o
);

    logic seen_q;

    // Marks cycles whose predecessor was out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    p_seq_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(mem_rd_o) && !$past(redir_i) && mem_rd_o
        |-> mem_addr_o == $past(mem_addr_o) + ADDR_W'(1));

    p_len_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid_o |-> (insn_len_o != '0) && (insn_len_o <= LEN_W'(MAX_BYTES)));

    p_gap_after_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid_o && insn_ready_i |=> !insn_valid_o);

    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid_o && !insn_ready_i && !redir_i
        |=> insn_valid_o && $stable(insn_op_o) && $stable(insn_pc_o) && $stable(insn_len_o));

    p_no_fetch_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid_o && !insn_ready_i |-> !mem_rd_o);

    p_abs_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redir_i && !redir_rel_i |=> mem_rd_o && (mem_addr_o == $past(redir_arg_i)));

    p_redirect_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redir_i |=> !insn_valid_o);

endmodule

bind vl_prefetch vl_prefetch_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MAX_BYTES (MAX_BYTES),
    .LEN_W     (LEN_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_rd_o     (mem_rd_o),
    .mem_addr_o   (mem_addr_o),
    .redir_i      (redir_i),
    .redir_rel_i  (redir_rel_i),
    .redir_arg_i  (redir_arg_i),
    .insn_valid_o (insn_valid_o),
    .insn_ready_i (insn_ready_i),
    .insn_op_o    (insn_op_o),
    .insn_len_o   (insn_len_o),
    .insn_pc_o    (insn_pc_o)
);

// File: tb/sim_vl_prefetch.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver walks the program image and queues the expected
// instructions; a monitor plays the execution engine and compares hand-overs.
module sim_vl_prefetch;

    localparam int          TOTAL    = 18;
    localparam logic [15:0] RST_ADDR = 16'h0040;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic        redir = 1'b0;
    logic        redir_rel = 1'b0;
    logic [15:0] redir_arg = 16'h0000;
    logic        valid;
    logic        ready = 1'b0;
    logic [7:0]  op;
    logic [23:0] args;
    logic [2:0]  len;
    logic [15:0] ipc;
    logic        stall;

    always #2.5 clk = ~clk;

    vl_prefetch u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .mem_rd_o     (mem_rd),
        .mem_addr_o   (mem_addr),
        .mem_rdata_i  (mem_rdata),
        .redir_i      (redir),
        .redir_rel_i  (redir_rel),
        .redir_arg_i  (redir_arg),
        .insn_valid_o (valid),
        .insn_ready_i (ready),
        .insn_op_o    (op),
        .insn_args_o  (args),
        .insn_len_o   (len),
        .insn_pc_o    (ipc),
        .stall_o      (stall)
    );

    logic [7:0] prog [256];

    // Program memory model: one-cycle read latency
    always @(posedge clk) if (mem_rd) mem_rdata <= prog[mem_addr[7:0]];

    typedef struct {
        logic [7:0]  op;
        logic [23:0] args;
        int          len;
        logic [15:0] pc;
        int          cyc;
    } item_t;

    item_t exp_q[$];
    int    checks = 0;
    int    fails = 0;
    int    hs_count = 0;
    bit    run_mon = 0;
    bit    fresh = 1;

    function automatic int len_of(logic [7:0] o);
        return int'(o[1:0]) + 1;
    endfunction

    function automatic int cyc_of(logic [7:0] o);
        return (o == 8'h00) ? 1 : int'(o[3:2]) + 2;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: queue n expected instructions starting at address a
    task automatic push_prog(input logic [15:0] a, input int n);
        logic [15:0] p = a;
        for (int i = 0; i < n; i++) begin
            item_t e;
            e.op   = prog[p[7:0]];
            e.len  = len_of(e.op);
            e.args = '0;
            for (int k = 1; k < e.len; k++) e.args[(k-1)*8 +: 8] = prog[8'(p[7:0] + 8'(k))];
            e.pc   = p;
            e.cyc  = cyc_of(e.op);
            exp_q.push_back(e);
            p = p + 16'(e.len);
        end
    endtask

    // Monitor and engine model
    initial begin
        int busy = 0;
        int cur_c = 0;
        int prev_c = 0;
        int stall_run = 0;
        bit hs_pend = 0;
        bit prev_hold = 0;
        bit prev_rd = 0;
        bit prev_redir = 0;
        logic [7:0]  prev_op = '0;
        logic [15:0] prev_pc = '0;
        logic [15:0] prev_addr = '0;
        forever begin
            @(negedge clk);
            if (!run_mon) continue;
            if (hs_pend) begin busy = cur_c; hs_pend = 0; end
            if (busy > 0) begin ready = 1'b0; busy--; end
            else ready = (hs_count < TOTAL);
            #1;
            chk("R7 stall pin", 32'(stall), 32'(ready & ~valid));
            if (ready && !valid) stall_run++;
            if (prev_hold) begin
                chk("R6 held valid", 32'(valid), 32'd1);
                chk("R6 held opcode", 32'(op), 32'(prev_op));
                chk("R6 held pc", 32'(ipc), 32'(prev_pc));
            end
            if (valid && !ready) chk("R6 no read while held", 32'(mem_rd), 32'd0);
            prev_hold = valid && !ready && !redir;
            prev_op = op;
            prev_pc = ipc;
            if (prev_rd && !prev_redir && mem_rd)
                chk("R3 sequential address", 32'(mem_addr), 32'(prev_addr + 16'd1));
            prev_rd = mem_rd;
            prev_addr = mem_addr;
            prev_redir = redir;
            if (valid && ready) begin
                if (exp_q.size() == 0) begin
                    chk("R4 unexpected instruction", 32'(ipc), 32'hFFFF_FFFF);
                end else begin
                    item_t e;
                    int want;
                    e = exp_q.pop_front();
                    chk("R4 opcode", 32'(op), 32'(e.op));
                    chk("R4 operands", 32'(args), 32'(e.args));
                    chk("R2 length", 32'(len), 32'(e.len));
                    chk("R4 address", 32'(ipc), 32'(e.pc));
                    want = (e.len > prev_c) ? e.len - prev_c : 0;
                    if (!fresh) chk("R5 R7 delay cycles", 32'(stall_run), 32'(want));
                    fresh = 0;
                    prev_c = e.cyc;
                    cur_c = e.cyc;
                end
                stall_run = 0;
                hs_pend = 1;
                hs_count++;
            end
        end
    end

    // Issue one redirect in the cycle after the latest acceptance
    task automatic jump(input bit rel, input logic [15:0] arg, input logic [15:0] tgt,
                        input int n, input string tag);
        @(negedge clk);
        redir = 1'b1;
        redir_rel = rel;
        redir_arg = arg;
        fresh = 1;
        exp_q.delete();
        push_prog(tgt, n);
        @(negedge clk);
        redir = 1'b0;
        #1;
        chk({tag, " read issued"}, 32'(mem_rd), 32'd1);
        chk({tag, " target"}, 32'(mem_addr), 32'(tgt));
        chk("R8 offer dropped", 32'(valid), 32'd0);
    endtask

    task automatic run_all();
        for (int i = 0; i < 256; i++) prog[i] = 8'(i) ^ 8'hA5;
        // program 1 at 0x0040: mixed lengths and execution times
        prog[8'h40] = 8'h00; prog[8'h41] = 8'h07; prog[8'h45] = 8'h02;
        prog[8'h48] = 8'h13; prog[8'h4C] = 8'h0C; prog[8'h4D] = 8'h21;
        prog[8'h4F] = 8'h0D; prog[8'h51] = 8'h32; prog[8'h54] = 8'h00;
        prog[8'h55] = 8'h06; prog[8'h58] = 8'h05;
        // program 2 at 0xFFF8, program 3 at 0x000E, program 4 at 0x0003
        prog[8'hF8] = 8'h01; prog[8'hFA] = 8'h0A; prog[8'hFD] = 8'h04;
        prog[8'h0E] = 8'h03; prog[8'h12] = 8'h00;
        prog[8'h03] = 8'h02; prog[8'h06] = 8'h01;

        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1 no offer in reset", 32'(valid), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        push_prog(RST_ADDR, 11);
        run_mon = 1;
        #1;
        chk("R1 first read issued", 32'(mem_rd), 32'd1);
        chk("R1 first read address", 32'(mem_addr), 32'(RST_ADDR));
        chk("R1 no offer yet", 32'(valid), 32'd0);

        wait (hs_count == 11);
        jump(1'b0, 16'hFFF8, 16'hFFF8, 3, "R8 absolute");
        wait (hs_count == 14);
        jump(1'b1, 16'h0010, 16'h000E, 2, "R9 relative wrap");
        wait (hs_count == 16);
        jump(1'b1, 16'h00F0, 16'h0003, 2, "R9 relative negative");
        wait (hs_count == TOTAL);
        repeat (4) @(negedge clk);
        chk("R4 all expected instructions seen", 32'(exp_q.size()), 32'd0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule